// File: doc/BRIEF.md
# Square-Wave Output Source Selector

This block drives one digital output pin of a waveform generator. The pin can carry one of three square-wave sources. The first is the most significant bit of the generated sample. The second is that bit divided by two. The third is an external comparator result that arrives as an asynchronous digital level. A six-bit control field picks the source. The same field can also float the pin by deasserting its output-enable. Some combinations are reserved: in those the pin is not driven, and a flag reports that the setting is invalid.

The sample MSB is registered once in the master clock domain. The divide-by-two is a toggle register that flips on every rising edge of that registered bit. The toggle keeps running whichever source is selected, so the divided wave stays in phase with the count of MSB rises. The comparator level passes through a two-flop synchroniser before it can be selected. Decoding of the control field is combinational, so the enable and the flag follow the control bits at once.

Top module: `sgnout_sel`

## Requirements
- R1: When control bit 5 (enable) is 0, `pin_oe` is 0, `pin_q` is 0 and `cfg_bad` is 0, whatever the other control bits are.
- R2: With bit 5=1, bit 1=0, bit 4=0 and bit 3=1, `pin_oe` is 1 and `pin_q` equals the value `msb_in` had at the previous rising clock edge.
- R3: With bit 5=1, bit 1=0, bit 4=0 and bit 3=0, `pin_oe` is 1 and `pin_q` is a toggle that changes once per rising edge of the registered MSB, one clock edge after `msb_in` is first seen high.
- R4: With bit 5=1, bit 1=0, bit 4=1 and bit 3=1, `pin_oe` is 1 and `pin_q` follows `cmp_in` two clock edges late.
- R5: With bit 5=1 and bit 1=1, `pin_oe` is 0, `pin_q` is 0 and `cfg_bad` is 1.
- R6: With bit 5=1, bit 1=0, bit 4=1 and bit 3=0, `pin_oe` is 0, `pin_q` is 0 and `cfg_bad` is 1.
- R7: While `rst_n` is low, `pin_oe` is 0. Reset clears the divider toggle, so the divided output starts at 0 once reset is released.
- R8: The divider counts MSB rises even while another source or the disabled state is selected. After switching to the divided source, the pin shows the parity of all rises since reset.
- R9: Control bits 0 and 2 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| msb_in | input | 1 | MSB of the generated sample, synchronous to `clk` |
| cmp_in | input | 1 | Comparator result, asynchronous |
| ctrl | input | 6 | Control field: bit 5 enable, bit 4 comparator source, bit 3 undivided, bit 1 triangle mode |
| pin_q | output | 1 | Pin data, 0 whenever `pin_oe` is 0 |
| pin_oe | output | 1 | Pin output-enable |
| cfg_bad | output | 1 | Reserved control combination selected |

## Verification
Enable and flag depend only on `ctrl` and reset, so they are checked in the same cycle the control field changes. The direct MSB and the divided toggle are due one rising edge after `msb_in` changes. The comparator is due after two edges. The bench drives every input 2 ns after a rising edge and samples just before driving again. Each expected value therefore counts exactly the edges between the stimulus and the sample. The divider is checked against a rise counter kept in the bench, which is advanced once per edge from the values the bench itself drove.

// File: rtl/sgnout_pkg.sv
package sgnout_pkg;

  localparam int CTRL_W   = 6;
  localparam int B_EN     = 5;
  localparam int B_CMP    = 4;
  localparam int B_NODIV  = 3;
  localparam int B_TRI    = 1;

  typedef enum logic [1:0] {
    SRC_OFF  = 2'd0,
    SRC_MSB  = 2'd1,
    SRC_HALF = 2'd2,
    SRC_CMP  = 2'd3
  } src_e;

  typedef struct packed {
    src_e src;
    logic drive;
    logic bad;
  } sel_t;

  function automatic sel_t decode_sel(input logic [CTRL_W-1:0] c);
    sel_t s;
    s.src   = SRC_OFF;
    s.drive = 1'b0;
    s.bad   = 1'b0;
    if (c[B_EN]) begin
      if (c[B_TRI] || (c[B_CMP] && !c[B_NODIV])) begin
        s.bad = 1'b1;
      end else begin
        s.drive = 1'b1;
        if (c[B_CMP])        s.src = SRC_CMP;
        else if (c[B_NODIV]) s.src = SRC_MSB;
        else                 s.src = SRC_HALF;
      end
    end
    return s;
  endfunction

endpackage

// File: rtl/sgnout_sync.sv
module sgnout_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/sgnout_div.sv
module sgnout_div (
  input  logic clk,
  input  logic rst_n,
  input  logic msb_in,
  output logic msb_q,
  output logic half_q,
  output logic msb_rise
);

  assign msb_rise = msb_in & ~msb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msb_q  <= 1'b0;
      half_q <= 1'b0;
    end else begin
      msb_q <= msb_in;
      if (msb_rise) half_q <= ~half_q;
    end
  end

  // R3: toggle flips exactly when the registered MSB rises
  a_r3_half_flips_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msb_q) |-> (half_q != $past(half_q)));
  a_r3_half_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(msb_q) |-> $stable(half_q));

endmodule

// File: rtl/sgnout_sel.sv
module sgnout_sel
  import sgnout_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              msb_in,
  input  logic              cmp_in,
  input  logic [CTRL_W-1:0] ctrl,
  output logic              pin_q,
  output logic              pin_oe,
  output logic              cfg_bad
);

  logic msb_q, half_q, msb_rise, cmp_s;
  sel_t sel;

  sgnout_div i_div (
    .clk(clk), .rst_n(rst_n), .msb_in(msb_in),
    .msb_q(msb_q), .half_q(half_q), .msb_rise(msb_rise)
  );

  sgnout_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst_n(rst_n), .d(cmp_in), .q(cmp_s)
  );

  assign sel     = decode_sel(ctrl);
  assign cfg_bad = sel.bad;
  assign pin_oe  = sel.drive & rst_n;

  always_comb begin
    unique case (sel.src)
      SRC_MSB:  pin_q = msb_q;
      SRC_HALF: pin_q = half_q;
      SRC_CMP:  pin_q = cmp_s;
      default:  pin_q = 1'b0;
    endcase
    if (!pin_oe) pin_q = 1'b0;
  end

  // R1: disabled pin is undriven and never flagged
  a_r1_off: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[B_EN] |-> (!pin_oe && !pin_q && !cfg_bad));
  // R2: direct source shows the registered MSB
  a_r2_direct: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[B_EN] && !ctrl[B_TRI] && !ctrl[B_CMP] && ctrl[B_NODIV]) |-> (pin_oe && pin_q == msb_q));
  // R5: triangle mode with enable is reserved
  a_r5_tri_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[B_EN] && ctrl[B_TRI]) |-> (!pin_oe && cfg_bad));
  // R6: comparator with divide is reserved
  a_r6_cmp_div_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[B_EN] && ctrl[B_CMP] && !ctrl[B_NODIV]) |-> (!pin_oe && cfg_bad));
  // R7: no drive while in reset
  always_comb if (!rst_n) a_r7_reset_oe: assert (!pin_oe);

endmodule

// File: tb/test_sgnout_sel.sv
module test_sgnout_sel;

  logic clk = 1'b0, rst_n = 1'b0, msb_in = 1'b0, cmp_in = 1'b0;
  logic [5:0] ctrl = 6'd0;
  logic pin_q, pin_oe, cfg_bad;
  int checks = 0, errors = 0;
  int rises = 0;
  logic prev_msb = 1'b0;

  always #5 clk = ~clk;

  sgnout_sel i_sgnout_sel (
    .clk(clk), .rst_n(rst_n), .msb_in(msb_in), .cmp_in(cmp_in),
    .ctrl(ctrl), .pin_q(pin_q), .pin_oe(pin_oe), .cfg_bad(cfg_bad)
  );

  // control, expected oe, expected flag, expected pin (with msb=1,cmp=1 held)
  localparam logic [8:0] VEC [10] = '{
    {6'b000000, 1'b0, 1'b0, 1'b0},  // R1
    {6'b011110, 1'b0, 1'b0, 1'b0},  // R1
    {6'b101000, 1'b1, 1'b0, 1'b1},  // R2
    {6'b111000, 1'b1, 1'b0, 1'b1},  // R4
    {6'b110000, 1'b0, 1'b1, 1'b0},  // R6
    {6'b100010, 1'b0, 1'b1, 1'b0},  // R5
    {6'b101010, 1'b0, 1'b1, 1'b0},  // R5
    {6'b111010, 1'b0, 1'b1, 1'b0},  // R5
    {6'b101101, 1'b1, 1'b0, 1'b1},  // R9
    {6'b111101, 1'b1, 1'b0, 1'b1}   // R9
  };

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  // one edge; bench tracks MSB rises from its own driven values
  task automatic step();
    @(posedge clk);
    if (rst_n) begin
      if (msb_in && !prev_msb) rises++;
      prev_msb = msb_in;
    end
    #2;
  endtask

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    ctrl = 6'b100000;
    step(); step();
    chk("R7 oe in reset", pin_oe, 1'b0);
    rst_n = 1'b1;
    step();
    chk("R7 half starts low", pin_q, 1'b0);
    chk("R7 oe after reset", pin_oe, 1'b1);

    // table walk
    msb_in = 1'b1; cmp_in = 1'b1;
    step(); step(); step();
    ctrl = 6'b101000; step();
    foreach (VEC[i]) begin
      ctrl = VEC[i][8:3];
      #1;
      chk($sformatf("R1/R2/R4/R5/R6/R9 oe vec%0d", i), pin_oe, VEC[i][2]);
      chk($sformatf("R1/R5/R6 bad vec%0d", i), cfg_bad, VEC[i][1]);
      chk($sformatf("R1/R2/R4/R9 pin vec%0d", i), pin_q, VEC[i][0]);
      step();
    end

    // R2 latency: one edge
    ctrl = 6'b101000; msb_in = 1'b0; step();
    msb_in = 1'b1; #1;
    chk("R2 before edge", pin_q, 1'b0);
    step();
    chk("R2 after one edge", pin_q, 1'b1);

    // R4 latency: two edges
    ctrl = 6'b111000; cmp_in = 1'b0; step(); step(); step();
    cmp_in = 1'b1; step();
    chk("R4 after one edge", pin_q, 1'b0);
    step();
    chk("R4 after two edges", pin_q, 1'b1);

    // R3: divided wave against bench rise count
    ctrl = 6'b100000;
    for (int k = 0; k < 24; k++) begin
      msb_in = (k % 5) < 2;
      step();
      chk("R3 divided parity", pin_q, rises[0]);
    end

    // R8: rises while disabled and in direct mode still count
    ctrl = 6'b001000;
    for (int k = 0; k < 6; k++) begin msb_in = k[0]; step(); end
    ctrl = 6'b101000;
    for (int k = 0; k < 3; k++) begin msb_in = ~k[0]; step(); end
    ctrl = 6'b100000; #1;
    chk("R8 parity kept across sources", pin_q, rises[0]);

    // R7: reset mid-run clears toggle
    msb_in = 1'b0; step();
    msb_in = 1'b1; step();
    rst_n = 1'b0; #1;
    chk("R7 oe low in reset", pin_oe, 1'b0);
    msb_in = 1'b0; step();
    rst_n = 1'b1; rises = 0; prev_msb = 1'b0; step();
    chk("R7 toggle cleared", pin_q, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule